// File: doc/BRIEF.md
# Flash Ready/Busy Timeout Monitor

This block watches the active-low ready/busy line of a NAND flash device and reports when the device stays busy for too long. Software programs a 20-bit limit, counted in clock cycles. The ready/busy line is resynchronised to the local clock. When the resynchronised line falls from ready to busy, the limit is copied into a down-counter. The counter then decrements once per clock for as long as the device stays busy. If it reaches zero while the device is still busy, a sticky error flag is raised. The flag drives an interrupt output when the interrupt is enabled.

A limit of zero turns the check off. A second busy entry reloads the counter from the current limit. When the device returns to ready early, the counter keeps its value until the next busy entry.

Software uses a small register port with a write strobe and a combinational read. A read-only status word packs the most recent device status byte with the live countdown. The status byte arrives as a valid-only input: it has no ready signal and no back-pressure, and a byte is taken in on every clock where its strobe is high.

Top module: `rb_timeout_mon`

## Requirements
- R1: The limit register at address 0 is 20 bits wide, readable and writable, and resets to zero. Bits 31:20 of the limit register always read as zero, whatever value was written to them.
- R2: While the limit is zero, the error flag is never set, however long the device stays busy.
- R3: `rb_n` passes through a two-stage synchroniser, and a high-to-low transition of the synchronised line counts as busy entry. The counter holds the limit from the third rising clock edge after `rb_n` falls. Every later busy entry reloads the counter.
- R4: The counter decrements by one on each clock while the synchronised line is busy. It holds its value while the line is ready. It stops at zero and never wraps.
- R5: The error flag is set on the same clock edge on which the counter steps from one to zero while busy.
- R6: The error flag stays set until a write to address 1 with bit 1 high. If that clear and a new timeout fall on the same edge, the flag stays set.
- R7: `irq` is high exactly when the error flag is set and the enable bit (address 1, bit 0) is set.
- R8: At address 2 the read-only status word holds the captured status byte in bits 31:24, zero in bits 23:20, and the live counter in bits 19:0. The byte is captured on each clock with `stat_vld` high and resets to zero. Writes to address 2 have no effect.
- R9: Reading address 1 returns the enable bit in bit 0 and the error flag in bit 1, with zeros elsewhere. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| rb_n | input | 1 | Asynchronous device ready/busy line, low = busy |
| stat_vld | input | 1 | Strobe marking a valid status byte |
| stat_byte | input | 8 | Device status byte from a completed status read |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Timeout interrupt request |

## Verification
Two events can fall on the same clock edge: the counter reaching zero, which sets the error flag, and a software write that clears the flag. The bench makes them coincide by counting edges from the moment it drops `rb_n`. It places the clearing write on the edge where a limit of four runs out, and then requires the flag to read back as set. The same run is repeated with the write one edge later, where the flag must read as clear. This shows that the first result comes from the ordering rule and not from the write being lost.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    ADR_LIMIT = 2'd0,
    ADR_CTRL  = 2'd1,
    ADR_STAT  = 2'd2,
    ADR_NONE  = 2'd3
  } rbt_addr_e;

  localparam int unsigned CTRL_IE_BIT  = 0;
  localparam int unsigned CTRL_ERR_BIT = 1;
endpackage

// File: rtl/rbt_sync.sv
module rbt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic busy,
  output logic busy_edge
);
  // stages 0..STAGES-1 resynchronise, stage STAGES keeps the previous value
  logic [STAGES:0] chain;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= line_n;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign busy      = ~chain[STAGES-1];
  assign busy_edge = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/rbt_counter.sv
module rbt_counter #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         busy,
  input  logic         armed,
  output logic [W-1:0] cnt,
  output logic         hit
);
  localparam logic [W-1:0] ONE = W'(1);

  assign hit = armed & busy & ~load & (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (busy && cnt != '0)  cnt <= cnt - ONE;
  end
endmodule

// File: rtl/rbt_regs.sv
module rbt_regs
  import rbt_pkg::*;
#(
  parameter int unsigned W      = 20,
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stat_vld,
  input  logic [STAT_W-1:0] stat_byte,
  input  logic              hit,
  input  logic [W-1:0]      cnt,
  output logic [DATA_W-1:0] rdata,
  output logic [W-1:0]      limit,
  output logic              ie,
  output logic              err
);
  localparam int unsigned PAD_W  = DATA_W - STAT_W - W;
  localparam int unsigned HIGH_W = DATA_W - W;

  logic [STAT_W-1:0] stat_q;
  logic              wr_limit, wr_ctrl;
  logic              unused_wdata;

  assign wr_limit     = wr && (addr == ADR_LIMIT);
  assign wr_ctrl      = wr && (addr == ADR_CTRL);
  assign unused_wdata = ^wdata[DATA_W-1:W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit  <= '0;
      ie     <= 1'b0;
      err    <= 1'b0;
      stat_q <= '0;
    end else begin
      if (wr_limit) limit <= wdata[W-1:0];
      if (wr_ctrl)  ie    <= wdata[CTRL_IE_BIT];
      if (hit)                                err <= 1'b1;
      else if (wr_ctrl && wdata[CTRL_ERR_BIT]) err <= 1'b0;
      if (stat_vld) stat_q <= stat_byte;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADR_LIMIT: rdata = {{HIGH_W{1'b0}}, limit};
      ADR_CTRL: begin
        rdata[CTRL_IE_BIT]  = ie;
        rdata[CTRL_ERR_BIT] = err;
      end
      ADR_STAT:  rdata = {stat_q, {PAD_W{1'b0}}, cnt};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/rb_timeout_mon.sv
module rb_timeout_mon
  import rbt_pkg::*;
#(
  parameter int unsigned TMO_W       = 20,
  parameter int unsigned STAT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rb_n,
  input  logic              stat_vld,
  input  logic [STAT_W-1:0] stat_byte,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic             busy, busy_edge, hit, ie, err;
  logic [TMO_W-1:0] cnt, limit;

  rbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_n(rb_n),
    .busy(busy), .busy_edge(busy_edge)
  );

  rbt_counter #(.W(TMO_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(busy_edge), .load_val(limit),
    .busy(busy), .armed(limit != '0), .cnt(cnt), .hit(hit)
  );

  rbt_regs #(.W(TMO_W), .STAT_W(STAT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .stat_vld(stat_vld), .stat_byte(stat_byte),
    .hit(hit), .cnt(cnt), .rdata(reg_rdata), .limit(limit),
    .ie(ie), .err(err)
  );

  assign irq = err & ie;
endmodule

// File: rtl/rbt_checker.sv
module rbt_checker #(
  parameter int unsigned W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         busy_edge,
  input logic [W-1:0] cnt,
  input logic [W-1:0] limit,
  input logic         err,
  input logic         ie,
  input logic         irq,
  input logic         reg_wr,
  input logic [1:0]   reg_addr,
  input logic [31:0]  reg_wdata,
  input logic [31:0]  reg_rdata
);
  logic clr;
  assign clr = reg_wr && reg_addr == 2'd1 && reg_wdata[1];

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_edge |=> cnt == $past(limit));

  p_hold_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !busy_edge) |=> $stable(cnt));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !busy_edge) |=> cnt == '0);

  p_set_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> cnt == '0);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> err);

  p_zero_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0 && !err) |=> !err);

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (err && ie));

  p_stat_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd2 |-> reg_rdata[23:20] == 4'd0);
endmodule

bind rb_timeout_mon rbt_checker #(.W(TMO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .busy_edge(busy_edge),
  .cnt(cnt), .limit(limit), .err(err), .ie(ie), .irq(irq),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata)
);

// File: tb/test_rb_timeout_mon.sv
`timescale 1ns/1ps
module test_rb_timeout_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rb_n = 1'b1;
  logic        stat_vld = 1'b0;
  logic [7:0]  stat_byte = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic ie_sw = 1'b0;

  always #2.5 clk = ~clk;

  rb_timeout_mon i_rb_timeout_mon (
    .clk(clk), .rst_n(rst_n), .rb_n(rb_n), .stat_vld(stat_vld),
    .stat_byte(stat_byte), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic settle_ready();
    @(negedge clk);
    rb_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(2'd0, d); chk("R1 reset limit", d, 32'h0);
    rd(2'd1, d); chk("R9 reset ctrl", d, 32'h0);
    rd(2'd2, d); chk("R8 reset status", d, 32'h0);
    chk("R7 reset irq", {31'b0, irq}, 32'h0);

    // R1 width and upper bits
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R1 upper bits zero", d, 32'h000F_FFFF);
    wr(2'd0, 32'h0001_2345);
    rd(2'd0, d); chk("R1 readback", d, 32'h0001_2345);
    rd(2'd3, d); chk("R9 unused address", d, 32'h0);

    // R8 status byte capture and write ignored
    @(negedge clk); stat_vld = 1'b1; stat_byte = 8'hA5;
    @(negedge clk); stat_vld = 1'b0; stat_byte = 8'h3C;
    rd(2'd2, d); chk("R8 status packing", d, 32'hA500_0000);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R8 write ignored", d, 32'hA500_0000);

    // R3 R4 R5 sweep of small limits
    for (int n = 1; n <= 8; n++) begin
      wr(2'd0, 32'(n));
      wr(2'd1, 32'h2);
      settle_ready();
      @(negedge clk); rb_n = 1'b0;
      for (int e = 1; e <= n + 5; e++) begin
        int k;
        cycle();
        k = e - 3;
        if (k >= 0) begin
          rd(2'd2, d);
          chk("R3 R4 countdown", {12'b0, d[19:0]}, (k >= n) ? 32'd0 : 32'(n - k));
          rd(2'd1, d);
          chk("R5 flag timing", {31'b0, d[1]}, {31'b0, (k >= n)});
        end
      end
    end

    // R7 interrupt gating, R6 sticky and clear
    chk("R7 irq off while disabled", {31'b0, irq}, 32'h0);
    wr(2'd1, 32'h1); ie_sw = 1'b1;
    chk("R7 irq on when enabled", {31'b0, irq}, 32'h1);
    repeat (5) cycle();
    rd(2'd1, d); chk("R6 flag sticky", d, 32'h3);
    wr(2'd1, 32'h3);
    rd(2'd1, d); chk("R6 clear by write", d, 32'h1);
    chk("R7 irq drops after clear", {31'b0, irq}, 32'h0);

    // R4 hold on early ready, R3 reload on new busy entry
    wr(2'd0, 32'd20);
    settle_ready();
    @(negedge clk); rb_n = 1'b0;
    repeat (8) cycle();
    rd(2'd2, d); chk("R4 mid count", {12'b0, d[19:0]}, 32'd15);
    rb_n = 1'b1;
    repeat (6) cycle();
    rd(2'd2, d); chk("R4 held after ready", {12'b0, d[19:0]}, 32'd13);
    repeat (10) cycle();
    rd(2'd2, d); chk("R4 still held", {12'b0, d[19:0]}, 32'd13);
    rd(2'd1, d); chk("R4 no flag on early ready", {31'b0, d[1]}, 32'h0);
    rb_n = 1'b0;
    repeat (3) cycle();
    rd(2'd2, d); chk("R3 reload on busy entry", {12'b0, d[19:0]}, 32'd20);
    settle_ready();

    // R2 zero limit disables
    wr(2'd0, 32'd0);
    settle_ready();
    @(negedge clk); rb_n = 1'b0;
    repeat (40) cycle();
    rd(2'd1, d); chk("R2 no flag with zero limit", {31'b0, d[1]}, 32'h0);
    rd(2'd2, d); chk("R2 counter at zero", {12'b0, d[19:0]}, 32'd0);
    chk("R2 no irq", {31'b0, irq}, 32'h0);

    // R6 collision: clear write on the edge the count expires
    for (int off = 0; off <= 1; off++) begin
      wr(2'd0, 32'd4);
      wr(2'd1, 32'h3);
      settle_ready();
      @(negedge clk); rb_n = 1'b0;
      repeat (6 + off) cycle();
      reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h3;
      cycle();
      reg_wr = 1'b0; reg_wdata = '0;
      rd(2'd1, d);
      chk(off == 0 ? "R6 set wins over clear" : "R6 later clear works",
          {31'b0, d[1]}, off == 0 ? 32'h1 : 32'h0);
      chk("R7 irq follows flag", {31'b0, irq}, off == 0 ? 32'h1 : 32'h0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule